// File: doc/BRIEF.md
# Frame Header Decoder and Bounds Checker

This block runs once at the start of every displayed frame of a panel controller. It takes the first 16-bit word of the frame's in-memory header, the palette-load mode, the panel type, the programmed panel width and height, the byte size of the frame buffer and the subpanel control word. From these it works out five things:

- the pixel depth;
- whether 16-bit pixels are read as 12-bit or 16-bit colour;
- how many header bytes to skip before the pixel data;
- which lines to draw;
- whether the frame fits inside its buffer.

A frame that does not fit raises a one-cycle sync-error strobe, which the surrounding controller uses to drop its enable.

A request enters on a valid/ready pair. `in_ready` is high only while the block is idle, and a request is taken on a cycle where both `in_valid` and `in_ready` are high. All request fields are captured on that edge. The result leaves on a second valid/ready pair. Once `out_valid` rises, it and every result field stay fixed until a cycle with `out_ready` high. The block then returns to idle on that edge. No new request is accepted while a result waits, so a stalled consumer holds off the producer.

The size check needs the pixel count width times height. The block forms it with a shift-and-add multiplier, one bit per cycle. A frame that is skipped answers on the cycle after acceptance, and a frame that is drawn answers DIM_W+3 cycles after acceptance.

Top module: `frame_hdr_check`

## Requirements
- R1: `in_ready` is high only when no result is pending. A result holds `out_valid` and all result fields stable until it is taken with `out_ready`, and `in_ready` returns in the cycle after that.
- R2: Load mode 1 (`load_mode`==2'd1) skips the frame: `out_skip`=1 and `out_fault`=0.
- R3: The depth code is header bits 14:12. Codes 1, 2 and 3 give 2, 4 and 8 bits per pixel. Codes 4 to 7 give 16 bits per pixel. Code 0 skips the frame without a fault.
- R4: `out_color16` is 1 only for 16 bits per pixel on an active-matrix panel (`active_panel`=1). For 16 bits per pixel on a passive panel it is 0, which selects 12-bit colour.
- R5: The pixel offset is 0 in load mode 2. In every other mode it is 512 bytes for depth codes 3 to 7 and 32 bytes for codes 1 and 2.
- R6: With W=`width_m1`+1 and H=`height_m1`+1, `out_fault` is 1 exactly when offset + floor(W*H*bpp/8) > `buf_bytes`+2. A skipped frame never faults.
- R7: `sync_err_pulse` is high for one cycle only, in the first cycle of `out_valid` of a faulting frame.
- R8: When subpanel bit 31 is 0, the first line is 0 and the line count is H.
- R9: When subpanel bits 31 and 29 are both 1, the first line is subpanel bits 25:16 and the line count is H. When bit 31 is 1 and bit 29 is 0, the first line is 0 and the line count is bits 25:16.
- R10: `out_stride` equals floor(W*bpp/8) bytes.
- R11: Counting the acceptance edge as cycle 1, `out_valid` is first high after edge 1 for a skipped frame and after edge DIM_W+3 for a drawn frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| hdr_word | input | 16 | First word of the frame header; bits 14:12 hold the depth code |
| load_mode | input | 2 | Palette-load mode: 1 skips the frame, 2 means no header |
| active_panel | input | 1 | 1 for an active-matrix panel, 0 for a passive panel |
| width_m1 | input | DIM_W | Panel width minus one |
| height_m1 | input | DIM_W | Panel height minus one |
| buf_bytes | input | SZ_W | Frame buffer size in bytes |
| subpanel | input | 32 | Subpanel word: bit 31 enable, bit 29 select, bits 25:16 line field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_skip | output | 1 | Frame is not drawn |
| out_fault | output | 1 | Frame does not fit its buffer |
| sync_err_pulse | output | 1 | One-cycle strobe on a fault |
| out_bpp | output | 5 | Bits per pixel (0 when the depth is unsupported) |
| out_color16 | output | 1 | 16-bit colour (1) or 12-bit colour (0) |
| out_offset | output | 10 | Bytes from frame base to pixel data |
| out_stride | output | DIM_W+2 | Bytes per line |
| out_first | output | 10 | First line to draw |
| out_lines | output | DIM_W+1 | Number of lines to draw |

## Verification
A multiplier counter that is off by one either cuts the last partial product or adds an extra one. Such a fault appears as a wrong `out_fault` only at the exact size boundary, so the bench steps `buf_bytes` one byte either side of the threshold for every depth. A decode or latch error shows on the first cycle of `out_valid`, and a wrong state transition shows as a wrong latency or as fields that move while the consumer stalls. The bench therefore counts cycles to `out_valid` and holds `out_ready` low across several cycles.

// File: rtl/fhd_pkg.sv
package fhd_pkg;
  localparam int SUBF_W      = 10;
  localparam int SUB_EN_BIT  = 31;
  localparam int SUB_SEL_BIT = 29;
  localparam int SUB_LSB     = 16;
  localparam int CODE_LSB    = 12;
  localparam int OFF_SHORT   = 32;
  localparam int OFF_LONG    = 512;
  localparam int OFF_W       = 10;

  typedef enum logic [1:0] {
    LM_HDR   = 2'd0,
    LM_OFF   = 2'd1,
    LM_NOHDR = 2'd2,
    LM_HDR2  = 2'd3
  } load_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MUL   = 2'd1,
    ST_CHECK = 2'd2,
    ST_DONE  = 2'd3
  } fhd_state_t;
endpackage

// File: rtl/fhd_decode.sv
module fhd_decode
  import fhd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      hdr_word,
  input  logic [1:0]       load_mode,
  input  logic             active_panel,
  output logic [2:0]       bpp_log2,
  output logic [4:0]       bpp,
  output logic             color16,
  output logic [OFF_W-1:0] offset,
  output logic             unsupported,
  output logic             no_frame
);
  logic [2:0] code;

  always_comb begin
    code        = hdr_word[CODE_LSB +: 3];
    unsupported = (code == 3'd0);
    no_frame    = (load_mode == LM_OFF);
    if (code == 3'd0)      bpp_log2 = 3'd0;
    else if (code >= 3'd4) bpp_log2 = 3'd4;
    else                   bpp_log2 = code;
    bpp     = unsupported ? 5'd0 : (5'd1 << bpp_log2);
    color16 = (bpp_log2 == 3'd4) && active_panel;
    if (load_mode == LM_NOHDR)  offset = '0;
    else if (code >= 3'd3)      offset = OFF_W'(OFF_LONG);
    else                        offset = OFF_W'(OFF_SHORT);
  end

  // R3
  bpp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unsupported |-> $countones(bpp) == 1);

  // R5
  off_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offset == '0) || (offset == OFF_W'(OFF_SHORT)) || (offset == OFF_W'(OFF_LONG)));
endmodule

// File: rtl/fhd_seq_mul.sv
module fhd_seq_mul #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [2*AW-1:0] product,
  output logic          last
);
  localparam int CW = $clog2(AW) + 1;

  logic [2*AW-1:0] mc_q;
  logic [AW-1:0]   mp_q;
  logic [CW-1:0]   cnt_q;
  logic            run_q;

  assign last = run_q && (cnt_q == CW'(AW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      mc_q    <= '0;
      mp_q    <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else if (start) begin
      product <= '0;
      mc_q    <= {{AW{1'b0}}, a};
      mp_q    <= b;
      cnt_q   <= '0;
      run_q   <= 1'b1;
    end else if (run_q) begin
      if (mp_q[0]) product <= product + mc_q;
      mc_q  <= mc_q << 1;
      mp_q  <= mp_q >> 1;
      cnt_q <= cnt_q + 1'b1;
      if (last) run_q <= 1'b0;
    end
  end

  // R11
  mul_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q < CW'(AW));

  // R6
  mul_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && !start |=> mp_q == '0);
endmodule

// File: rtl/fhd_line_window.sv
module fhd_line_window
  import fhd_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic [31:0]      subpanel,
  input  logic [DIM_W-1:0] height_m1,
  output logic [SUBF_W-1:0] first_line,
  output logic [DIM_W:0]   line_count
);
  logic [SUBF_W-1:0] field;
  logic [DIM_W:0]    full_h;

  always_comb begin
    field      = subpanel[SUB_LSB +: SUBF_W];
    full_h     = {1'b0, height_m1} + 1'b1;
    first_line = '0;
    line_count = full_h;
    if (subpanel[SUB_EN_BIT]) begin
      if (subpanel[SUB_SEL_BIT]) first_line = field;
      else                       line_count = (DIM_W+1)'(field);
    end
  end
endmodule

// File: rtl/frame_hdr_check.sv
module frame_hdr_check
  import fhd_pkg::*;
#(
  parameter int DIM_W = 10,
  parameter int SZ_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       hdr_word,
  input  logic [1:0]        load_mode,
  input  logic              active_panel,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic [SZ_W-1:0]   buf_bytes,
  input  logic [31:0]       subpanel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_skip,
  output logic              out_fault,
  output logic              sync_err_pulse,
  output logic [4:0]        out_bpp,
  output logic              out_color16,
  output logic [OFF_W-1:0]  out_offset,
  output logic [DIM_W+1:0]  out_stride,
  output logic [SUBF_W-1:0] out_first,
  output logic [DIM_W:0]    out_lines
);
  localparam int CNT_W  = DIM_W + 1;
  localparam int PW     = 2 * CNT_W;
  localparam int BIT_W  = PW + 4;
  localparam int CMP_W  = ((BIT_W > SZ_W) ? BIT_W : SZ_W) + 2;
  localparam int SBIT_W = CNT_W + 4;

  fhd_state_t state_q, state_d;

  logic [15:0]      hdr_q;
  logic [1:0]       mode_q;
  logic             panel_q;
  logic [DIM_W-1:0] wm1_q, hm1_q;
  logic [SZ_W-1:0]  size_q;
  logic [31:0]      sub_q;
  logic             skip_q, fault_q, pulse_q;

  logic             idle, accept;
  logic [15:0]      dec_hdr;
  logic [1:0]       dec_mode;
  logic             dec_panel;
  logic [2:0]       bpp_log2;
  logic [4:0]       bpp;
  logic             color16, unsupported, no_frame, skip_now;
  logic [OFF_W-1:0] offset;
  logic [CNT_W-1:0] w_in, h_in, w_q;
  logic [PW-1:0]    prod;
  logic             mul_last;
  logic [BIT_W-1:0] frame_bits;
  logic [CMP_W-1:0] need, limit;
  logic             fault_d;
  logic [SBIT_W-1:0] line_bits;

  assign idle      = (state_q == ST_IDLE);
  assign in_ready  = idle;
  assign out_valid = (state_q == ST_DONE);
  assign accept    = in_valid && idle;

  // decode straight from the ports while idle, from captured copies otherwise
  assign dec_hdr   = idle ? hdr_word     : hdr_q;
  assign dec_mode  = idle ? load_mode    : mode_q;
  assign dec_panel = idle ? active_panel : panel_q;

  fhd_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdr_word     (dec_hdr),
    .load_mode    (dec_mode),
    .active_panel (dec_panel),
    .bpp_log2     (bpp_log2),
    .bpp          (bpp),
    .color16      (color16),
    .offset       (offset),
    .unsupported  (unsupported),
    .no_frame     (no_frame)
  );

  assign skip_now = no_frame || unsupported;
  assign w_in     = {1'b0, width_m1}  + 1'b1;
  assign h_in     = {1'b0, height_m1} + 1'b1;
  assign w_q      = {1'b0, wm1_q} + 1'b1;

  fhd_seq_mul #(.AW(CNT_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept && !skip_now),
    .a       (w_in),
    .b       (h_in),
    .product (prod),
    .last    (mul_last)
  );

  fhd_line_window #(.DIM_W(DIM_W)) u_win (
    .subpanel   (sub_q),
    .height_m1  (hm1_q),
    .first_line (out_first),
    .line_count (out_lines)
  );

  always_comb begin
    frame_bits = BIT_W'(prod) << bpp_log2;
    need       = CMP_W'(frame_bits >> 3) + CMP_W'(offset);
    limit      = CMP_W'(size_q) + CMP_W'(2);
    fault_d    = need > limit;
    line_bits  = SBIT_W'(w_q) << bpp_log2;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)    state_d = skip_now ? ST_DONE : ST_MUL;
      ST_MUL:   if (mul_last)  state_d = ST_CHECK;
      ST_CHECK:                state_d = ST_DONE;
      ST_DONE:  if (out_ready) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      mode_q  <= '0;
      panel_q <= 1'b0;
      wm1_q   <= '0;
      hm1_q   <= '0;
      size_q  <= '0;
      sub_q   <= '0;
      skip_q  <= 1'b0;
      fault_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= 1'b0;
      if (accept) begin
        hdr_q   <= hdr_word;
        mode_q  <= load_mode;
        panel_q <= active_panel;
        wm1_q   <= width_m1;
        hm1_q   <= height_m1;
        size_q  <= buf_bytes;
        sub_q   <= subpanel;
        skip_q  <= skip_now;
        fault_q <= 1'b0;
      end
      if (state_q == ST_CHECK) begin
        fault_q <= fault_d;
        pulse_q <= fault_d;
      end
    end
  end

  assign out_skip       = skip_q;
  assign out_fault      = fault_q;
  assign sync_err_pulse = pulse_q;
  assign out_bpp        = bpp;
  assign out_color16    = color16;
  assign out_offset     = offset;
  assign out_stride     = (DIM_W+2)'(line_bits >> 3);

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bpp) && $stable(out_offset)
      && $stable(out_lines) && $stable(out_first) && $stable(out_fault) && $stable(out_skip));

  // R7
  pulse_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_pulse |-> out_valid && out_fault && $rose(out_valid));

  // R6
  skip_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_skip |-> !out_fault);

  // R1
  ready_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);
endmodule

// File: tb/tb_frame_hdr_check.sv
module tb_frame_hdr_check;
  localparam int DIM_W = 10;
  localparam int SZ_W  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [15:0] hdr_word = '0;
  logic [1:0]  load_mode = '0;
  logic        active_panel = 1'b0;
  logic [DIM_W-1:0] width_m1 = '0, height_m1 = '0;
  logic [SZ_W-1:0]  buf_bytes = '0;
  logic [31:0]      subpanel = '0;
  logic out_valid, out_ready = 1'b1;
  logic out_skip, out_fault, sync_err_pulse, out_color16;
  logic [4:0] out_bpp;
  logic [9:0] out_offset, out_first;
  logic [DIM_W+1:0] out_stride;
  logic [DIM_W:0]   out_lines;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  frame_hdr_check #(.DIM_W(DIM_W), .SZ_W(SZ_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hdr_word(hdr_word), .load_mode(load_mode), .active_panel(active_panel),
    .width_m1(width_m1), .height_m1(height_m1), .buf_bytes(buf_bytes),
    .subpanel(subpanel), .out_valid(out_valid), .out_ready(out_ready),
    .out_skip(out_skip), .out_fault(out_fault), .sync_err_pulse(sync_err_pulse),
    .out_bpp(out_bpp), .out_color16(out_color16), .out_offset(out_offset),
    .out_stride(out_stride), .out_first(out_first), .out_lines(out_lines)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bpp_of(input int code);
    if (code == 0) return 0;
    if (code >= 4) return 16;
    return 1 << code;
  endfunction

  // one request; returns after the result was observed and taken (unless hold>0)
  task automatic run(input int code, input int mode, input int panel, input int wm1,
                     input int hm1, input int size, input logic [31:0] sub, input int hold);
    int lat, b, w, h, off, need, exp_first, exp_lines, fld;
    bit skip, fault;
    @(negedge clk);
    chk("R1 in_ready idle", int'(in_ready), 1);
    hdr_word = {1'b1, 3'(code), 12'hA5C};
    load_mode = 2'(mode); active_panel = panel[0];
    width_m1 = DIM_W'(wm1); height_m1 = DIM_W'(hm1);
    buf_bytes = SZ_W'(size); subpanel = sub;
    out_ready = (hold == 0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    b = bpp_of(code); w = wm1 + 1; h = hm1 + 1;
    skip = (mode == 1) || (code == 0);
    off = (mode == 2) ? 0 : ((code >= 3) ? 512 : 32);
    need = off + (w * h * b) / 8;
    fault = !skip && (need > size + 2);
    fld = int'(sub[25:16]);
    exp_first = (sub[31] && sub[29]) ? fld : 0;
    exp_lines = (sub[31] && !sub[29]) ? fld : h;
    chk("R11 latency", lat, skip ? 1 : DIM_W + 3);
    chk(mode == 1 ? "R2 skip" : "R3 skip", int'(out_skip), int'(skip));
    chk("R6 fault", int'(out_fault), int'(fault));
    chk("R7 pulse", int'(sync_err_pulse), int'(fault));
    if (!skip) begin
      chk("R3 bpp", int'(out_bpp), b);
      chk("R4 color16", int'(out_color16), int'(b == 16 && panel != 0));
      chk("R5 offset", int'(out_offset), off);
      chk("R10 stride", int'(out_stride), (w * b) / 8);
      chk(sub[31] ? "R9 first" : "R8 first", int'(out_first), exp_first);
      chk(sub[31] ? "R9 lines" : "R8 lines", int'(out_lines), exp_lines);
    end
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R1 held valid", int'(out_valid), 1);
        chk("R1 no ready", int'(in_ready), 0);
        chk("R7 pulse once", int'(sync_err_pulse), 0);
        chk("R1 held fault", int'(out_fault), int'(fault));
        chk("R1 held lines", int'(out_lines), exp_lines);
      end
      out_ready = 1'b1;
    end
    @(negedge clk);
    chk("R1 taken", int'(out_valid), 0);
    chk("R1 ready back", int'(in_ready), 1);
    chk("R7 pulse low", int'(sync_err_pulse), 0);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset in_ready", int'(in_ready), 1);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R7 reset pulse", int'(sync_err_pulse), 0);
    rst_n = 1'b1;
    // sweep: every mode, depth code and panel type at two panel sizes
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 8; c++)
        for (int p = 0; p < 2; p++) begin
          run(c, m, p, 0, 0, 24'hFFFFFF, 32'h0, 0);
          run(c, m, p, 39, 9, 24'hFFFFFF, 32'h0, 0);
        end
    // fault boundary one byte either side of the threshold
    for (int c = 1; c < 8; c++)
      for (int m = 0; m < 3; m += 2) begin
        int off = (m == 2) ? 0 : ((c >= 3) ? 512 : 32);
        int need = off + (20 * 7 * bpp_of(c)) / 8;
        run(c, m, c & 1, 19, 6, need - 2, 32'h0, 0);
        run(c, m, c & 1, 19, 6, need - 3, 32'h0, 0);
      end
    // largest panel: product uses every multiplier bit
    run(4, 0, 1, 1023, 1023, 2097152 + 510, 32'h0, 0);
    run(4, 0, 1, 1023, 1023, 2097152 + 509, 32'h0, 0);
    // subpanel combinations
    run(3, 0, 0, 15, 99, 24'hFFFFFF, 32'hA005_0000, 0);
    run(3, 0, 0, 15, 99, 24'hFFFFFF, 32'h8005_0000, 0);
    run(2, 2, 1, 15, 99, 24'hFFFFFF, 32'hA3FF_0000, 0);
    run(2, 2, 1, 15, 99, 24'hFFFFFF, 32'h83FF_0000, 0);
    run(5, 0, 0, 15, 99, 24'hFFFFFF, 32'h2123_0000, 0);
    // back-pressure on a faulting and on a skipped frame
    run(5, 0, 0, 63, 63, 100, 32'h8010_0000, 5);
    run(0, 0, 1, 63, 63, 100, 32'h0, 4);
    finish_up();
  end
endmodule